// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a bank of eight 64-bit performance counters for one agent on a chip. Each counter watches a 256-wide vector of one-cycle event pulses. Software picks one pulse for each counter by writing an 8-bit event code. A counter advances by one in any cycle where its chosen pulse is high, the bank is globally enabled, and the counter's own enable bit is set.

Software reaches the bank through a simple register port with byte offsets and 32-bit data. A request with `req_write` low is a read, and its data comes back on the next cycle. Software can preload a counter, for example to place it just below the wrap point so that an overflow interrupt arrives after a known number of events. When a counter wraps past all ones, it sets a sticky status bit. The interrupt line goes high while any status bit is set and not masked.

Two arrangements of the interrupt registers exist, and the `IRQ_LAYOUT` parameter picks one:

- Layout 0 has a read-only status register and a separate clear register.
- Layout 1 has a single status register that is cleared by writing a 1 to a bit.

Top module: `evctr_bank`

## Requirements
- R1: After reset, every counter, the global enable, the counter-enable bits and every status bit read 0, every mask bit reads 1, and `irq` is low.
- R2: Bit 0 of the control register at 0x1C00 is the global enable. While it is 0, no counter advances.
- R3: In the counter-enable register at 0x1C04, bit i enables counter i. A counter whose bit is 0 holds its value.
- R4: Counters 0 to 3 take their event codes from the select register at 0x1C80, and counters 4 to 7 from the one at 0x1C84. Counter i uses bits 8*(i mod 4)+7 down to 8*(i mod 4). In a cycle where `evt_pulse[code]` is high and both enables are set, the counter rises by exactly one, and the new value is visible from the next clock.
- R5: Counter i has its low word at 0x1D00+8*i and its high word at 0x1D04+8*i. A write replaces only the addressed half, and a read returns that half.
- R6: If software writes either half of a counter in the same cycle as that counter's increment, the write wins and there is no increment in that cycle.
- R7: When a counter steps from all ones to zero, status bit i is set. It stays set until software clears it.
- R8: In the mask register a 1 masks counter i and a 0 enables it. `irq` is high exactly when some status bit is set and its mask bit is 0.
- R9: With `IRQ_LAYOUT`=0, the mask is at 0x1C70 and the status is at 0x1C78. The status register is read-only. Writing a 1 to bit i of 0x1C7C clears status bit i, and 0x1C7C reads 0.
- R10: With `IRQ_LAYOUT`=1, the status is at 0x1C70 and writing a 1 to a bit there clears that bit. The mask is at 0x1C74.
- R11: Offset 0x1CF0 reads the `VERSION` parameter value, and writes to it are ignored.
- R12: A read request gives `rsp_valid` high on the next cycle, with the register value from the request cycle. Unmapped offsets read 0. `rsp_valid` is low after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| evt_pulse | input | 256 | Event pulses, indexed by event code |
| irq | output | 1 | Overflow interrupt |

## Verification
Directed phases use one pulse per code on a partial enable set, which separates counters that advance from counters that hold. They also toggle the global enable, to separate the global gate from the per-counter gates. A long pseudo-random phase fires several codes at once while reading every counter half. It checks the event-code byte lanes and shows whether two counters ever respond to the same pulse. Preloads just below the wrap point, a write made against an active pulse, and a mask and clear sequence on each of the two interrupt layouts distinguish write priority, sticky status and the masking logic.

// File: rtl/evctr_pkg.sv
// Package: shared offsets of the event counter bank.
// Assumes 16-bit byte offsets and 32-bit data words.
package evctr_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 16'h1C00;
    localparam logic [ADDR_W-1:0] OFF_CTREN  = 16'h1C04;
    localparam logic [ADDR_W-1:0] OFF_A_MASK = 16'h1C70;
    localparam logic [ADDR_W-1:0] OFF_A_STAT = 16'h1C78;
    localparam logic [ADDR_W-1:0] OFF_A_CLR  = 16'h1C7C;
    localparam logic [ADDR_W-1:0] OFF_B_STAT = 16'h1C70;
    localparam logic [ADDR_W-1:0] OFF_B_MASK = 16'h1C74;
    localparam logic [ADDR_W-1:0] OFF_SEL0   = 16'h1C80;
    localparam logic [ADDR_W-1:0] OFF_VER    = 16'h1CF0;
    localparam logic [ADDR_W-1:0] OFF_CNT0   = 16'h1D00;
endpackage

// File: rtl/evctr_counter.sv
// Module: one preloadable event counter.
// It picks its event pulse by code and advances by one when enabled.
// A software write to either half wins over an increment in the same cycle.
// Assumes 32 < CTR_W <= 64 and a pulse vector of 2**CODE_W entries.
module evctr_counter #(
    parameter int unsigned CTR_W  = 64,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned NUM_EVT = 1 << CODE_W,
    localparam int unsigned HI_W    = CTR_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic [CODE_W-1:0] code,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    output logic [CTR_W-1:0]  value,
    output logic              wrap
);
    logic inc;

    // Increment qualifier: enabled, event seen, no software write this cycle.
    always_comb begin
        inc  = count_en && evt_pulse[code] && !(wr_lo || wr_hi);
        wrap = inc && (value == {CTR_W{1'b1}});
    end

    // Counter state: a preload first, then the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_lo) begin
            value[31:0] <= wdata;
        end else if (wr_hi) begin
            value[CTR_W-1:32] <= wdata[HI_W-1:0];
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/evctr_irq.sv
// Module: overflow status, mask and interrupt line.
// Status bits are sticky. Within a cycle a new overflow wins over a clear.
// The mask resets to all ones, so every interrupt starts masked.
module evctr_irq #(
    parameter int unsigned NUM_CTR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] set_vec,
    input  logic [NUM_CTR-1:0] clr_vec,
    input  logic               mask_wr,
    input  logic [NUM_CTR-1:0] mask_wdata,
    output logic [NUM_CTR-1:0] status,
    output logic [NUM_CTR-1:0] mask,
    output logic               irq
);
    // Status update: clear the requested bits, then merge new overflows.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // Mask register: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_wr) mask <= mask_wdata;
    end

    // Interrupt output: OR of the status bits that are not masked.
    always_comb irq = |(status & ~mask);
endmodule

// File: rtl/evctr_bank.sv
// Module: top of the event counter bank.
// It decodes the register port, holds the control, enable and select
// registers, and instantiates the counters and the interrupt logic.
// A read returns its data one cycle after the request. One request per cycle.
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int unsigned NUM_CTR    = 8,
    parameter int unsigned CTR_W      = 64,
    parameter int unsigned CODE_W     = 8,
    parameter int unsigned IRQ_LAYOUT = 0,
    parameter logic [31:0] VERSION    = 32'h0001_0200,
    localparam int unsigned NUM_EVT   = 1 << CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    output logic                irq
);
    localparam int unsigned CODES_PER_SEL = DATA_W / CODE_W;
    localparam int unsigned NUM_SEL = (NUM_CTR + CODES_PER_SEL - 1) / CODES_PER_SEL;
    localparam logic [ADDR_W-1:0] OFF_MASK = (IRQ_LAYOUT == 0) ? OFF_A_MASK : OFF_B_MASK;
    localparam logic [ADDR_W-1:0] OFF_STAT = (IRQ_LAYOUT == 0) ? OFF_A_STAT : OFF_B_STAT;
    localparam logic [ADDR_W-1:0] OFF_CLR  = (IRQ_LAYOUT == 0) ? OFF_A_CLR  : OFF_B_STAT;

    logic                     wr;
    logic                     glob_en_q;
    logic [NUM_CTR-1:0]       ctr_en_q;
    logic [DATA_W-1:0]        sel_q [NUM_SEL];
    logic [NUM_CTR-1:0]       wr_lo, wr_hi, wrap_vec;
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       irq_status, irq_mask, clr_vec;
    logic                     mask_wr;
    logic [DATA_W-1:0]        rd_val;

    // Write strobe shared by every register.
    always_comb wr = req_valid && req_write;

    // Global enable and per-counter enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en_q <= 1'b0;
            ctr_en_q  <= '0;
        end else begin
            if (wr && req_addr == OFF_CTRL)  glob_en_q <= req_wdata[0];
            if (wr && req_addr == OFF_CTREN) ctr_en_q  <= req_wdata[NUM_CTR-1:0];
        end
    end

    // Event select registers, each packing several codes.
    for (genvar j = 0; j < NUM_SEL; j++) begin : g_sel
        localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(OFF_SEL0 + 4 * j);
        // One select register, written as a whole word.
        always_ff @(posedge clk) begin
            if (!rst_n)                        sel_q[j] <= '0;
            else if (wr && req_addr == SEL_ADDR) sel_q[j] <= req_wdata;
        end
    end

    // Counters, each with its own address pair and code lane.
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(OFF_CNT0 + 8 * i);
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(OFF_CNT0 + 8 * i + 4);
        localparam int unsigned SREG  = i / CODES_PER_SEL;
        localparam int unsigned SLANE = (i % CODES_PER_SEL) * CODE_W;

        // Address match for the two halves of this counter.
        always_comb begin
            wr_lo[i] = wr && (req_addr == LO_ADDR);
            wr_hi[i] = wr && (req_addr == HI_ADDR);
        end

        evctr_counter #(
            .CTR_W  (CTR_W),
            .CODE_W (CODE_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .count_en  (glob_en_q && ctr_en_q[i]),
            .code      (sel_q[SREG][SLANE +: CODE_W]),
            .evt_pulse (evt_pulse),
            .wr_lo     (wr_lo[i]),
            .wr_hi     (wr_hi[i]),
            .wdata     (req_wdata),
            .value     (cnt_flat[i*CTR_W +: CTR_W]),
            .wrap      (wrap_vec[i])
        );
    end

    // Interrupt register strobes for the chosen layout.
    always_comb begin
        mask_wr = wr && (req_addr == OFF_MASK);
        clr_vec = (wr && req_addr == OFF_CLR) ? req_wdata[NUM_CTR-1:0] : '0;
    end

    evctr_irq #(
        .NUM_CTR (NUM_CTR)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (wrap_vec),
        .clr_vec    (clr_vec),
        .mask_wr    (mask_wr),
        .mask_wdata (req_wdata[NUM_CTR-1:0]),
        .status     (irq_status),
        .mask       (irq_mask),
        .irq        (irq)
    );

    // Read mux: picks the addressed register, 0 for unmapped offsets.
    always_comb begin
        rd_val = '0;
        if (req_addr == OFF_CTRL)  rd_val = {{(DATA_W-1){1'b0}}, glob_en_q};
        if (req_addr == OFF_CTREN) rd_val[NUM_CTR-1:0] = ctr_en_q;
        if (req_addr == OFF_MASK)  rd_val[NUM_CTR-1:0] = irq_mask;
        if (req_addr == OFF_STAT)  rd_val[NUM_CTR-1:0] = irq_status;
        if (req_addr == OFF_VER)   rd_val = VERSION;
        for (int j = 0; j < NUM_SEL; j++) begin
            if (req_addr == ADDR_W'(OFF_SEL0 + 4 * j)) rd_val = sel_q[j];
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (req_addr == ADDR_W'(OFF_CNT0 + 8 * i))
                rd_val = cnt_flat[i*CTR_W +: 32];
            if (req_addr == ADDR_W'(OFF_CNT0 + 8 * i + 4))
                rd_val = DATA_W'(cnt_flat[i*CTR_W + 32 +: (CTR_W-32)]);
        end
    end

    // Read response register: one cycle after the read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/evctr_bank_chk.sv
// Module: assertion checker for evctr_bank, attached through bind.
// It watches the port handshake, the counter values and the interrupt state.
module evctr_bank_chk #(
    parameter int unsigned NUM_CTR = 8,
    parameter int unsigned CTR_W   = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_write,
    input logic                     glob_en_q,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic [NUM_CTR-1:0]       irq_status,
    input logic [NUM_CTR-1:0]       irq_mask,
    input logic                     rsp_valid,
    input logic                     irq
);
    // R2
    global_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en_q && !(req_valid && req_write)) |=> $stable(cnt_flat));

    // R12
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R12
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R8
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == {NUM_CTR{1'b1}}) |-> !irq);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        // R4
        step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid && req_write) |=>
            (cnt_flat[i*CTR_W +: CTR_W] == $past(cnt_flat[i*CTR_W +: CTR_W]) ||
             cnt_flat[i*CTR_W +: CTR_W] == $past(cnt_flat[i*CTR_W +: CTR_W]) + 1'b1));

        // R7
        status_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_status[i]) |-> (cnt_flat[i*CTR_W +: CTR_W] == '0));
    end
endmodule

bind evctr_bank evctr_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W)
) u_evctr_bank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .glob_en_q  (glob_en_q),
    .cnt_flat   (cnt_flat),
    .irq_status (irq_status),
    .irq_mask   (irq_mask),
    .rsp_valid  (rsp_valid),
    .irq        (irq)
);

// File: tb/evctr_bank_bench.sv
// Bench: a behavioural model of layout 0 checked against u_evctr_bank on every
// clock, plus directed checks on a layout 1 instance.
module evctr_bank_bench;
    localparam logic [31:0] VER = 32'h0001_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq;
    logic        b_valid = 1'b0, b_write = 1'b0;
    logic [15:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic        b_rsp_valid;
    logic [31:0] b_rsp_rdata;
    logic        b_irq;
    logic [255:0] evt_pulse = '0;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    evctr_bank #(.IRQ_LAYOUT(0), .VERSION(VER)) u_evctr_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .evt_pulse(evt_pulse), .irq(irq));

    evctr_bank #(.IRQ_LAYOUT(1), .VERSION(VER)) u_evctr_bank_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_write(b_write),
        .req_addr(b_addr), .req_wdata(b_wdata), .rsp_valid(b_rsp_valid),
        .rsp_rdata(b_rsp_rdata), .evt_pulse(evt_pulse), .irq(b_irq));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model of the layout 0 instance.
    longint unsigned m_cnt [8];
    bit        m_glob;
    bit [7:0]  m_en, m_mask, m_stat;
    bit [31:0] m_sel [2];
    bit        e_valid;
    bit [31:0] e_data;
    string     e_tag;

    function automatic bit [31:0] mread(input bit [15:0] a);
        if (a == 16'h1C00) return {31'b0, m_glob};
        if (a == 16'h1C04) return {24'b0, m_en};
        if (a == 16'h1C70) return {24'b0, m_mask};
        if (a == 16'h1C78) return {24'b0, m_stat};
        if (a == 16'h1C80) return m_sel[0];
        if (a == 16'h1C84) return m_sel[1];
        if (a == 16'h1CF0) return VER;
        for (int i = 0; i < 8; i++) begin
            if (a == 16'(16'h1D00 + 8*i))     return m_cnt[i][31:0];
            if (a == 16'(16'h1D00 + 8*i + 4)) return m_cnt[i][63:32];
        end
        return 32'h0;
    endfunction

    function automatic string atag(input bit [15:0] a);
        if (a == 16'h1C00) return "R2";
        if (a == 16'h1C04) return "R3";
        if (a == 16'h1C80 || a == 16'h1C84) return "R4";
        if (a >= 16'h1D00 && a < 16'h1D40) return "R5";
        if (a >= 16'h1C70 && a <= 16'h1C7C) return "R9";
        if (a == 16'h1CF0) return "R11";
        return "R12";
    endfunction

    // Model step on each rising edge, on the same inputs the design sees.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_glob = 0; m_en = 0; m_mask = 8'hFF; m_stat = 0;
            m_sel[0] = 0; m_sel[1] = 0; e_valid = 0;
        end else begin
            bit [7:0] setv, clrv;
            bit       wrq;
            setv = 0; clrv = 0;
            wrq = req_valid && req_write;
            e_valid = req_valid && !req_write;
            if (e_valid) begin
                e_data = mread(req_addr);
                e_tag  = atag(req_addr);
            end
            for (int i = 0; i < 8; i++) begin
                int  code;
                bit  hit_w;
                code  = (m_sel[i/4] >> (8*(i%4))) & 8'hFF;
                hit_w = wrq && (req_addr == 16'(16'h1D00 + 8*i) || req_addr == 16'(16'h1D04 + 8*i));
                if (m_glob && m_en[i] && evt_pulse[code] && !hit_w) begin
                    if (m_cnt[i] == 64'hFFFF_FFFF_FFFF_FFFF) setv[i] = 1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (wrq) begin
                if (req_addr == 16'h1C00) m_glob = req_wdata[0];
                if (req_addr == 16'h1C04) m_en = req_wdata[7:0];
                if (req_addr == 16'h1C70) m_mask = req_wdata[7:0];
                if (req_addr == 16'h1C7C) clrv = req_wdata[7:0];
                if (req_addr == 16'h1C80) m_sel[0] = req_wdata;
                if (req_addr == 16'h1C84) m_sel[1] = req_wdata;
                for (int i = 0; i < 8; i++) begin
                    if (req_addr == 16'(16'h1D00 + 8*i)) m_cnt[i][31:0]  = req_wdata;
                    if (req_addr == 16'(16'h1D04 + 8*i)) m_cnt[i][63:32] = req_wdata;
                end
            end
            m_stat = (m_stat & ~clrv) | setv;
        end
    end

    // Compare on every falling edge, after reset is released.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rsp_valid == e_valid, "R12", rsp_valid, e_valid);
            if (e_valid && rsp_valid) chk(rsp_rdata == e_data, e_tag, rsp_rdata, e_data);
            chk(irq == |(m_stat & ~m_mask), "R8", irq, |(m_stat & ~m_mask));
        end
    end

    task automatic wr_a(input bit [15:0] a, input bit [31:0] d);
        @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk); req_valid = 0; req_write = 0;
    endtask

    task automatic rd_a(input bit [15:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk); req_valid = 0;
        chk(rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    task automatic wr_b(input bit [15:0] a, input bit [31:0] d);
        @(negedge clk); b_valid = 1; b_write = 1; b_addr = a; b_wdata = d;
        @(negedge clk); b_valid = 0; b_write = 0;
    endtask

    task automatic rd_b(input bit [15:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk); b_valid = 1; b_write = 0; b_addr = a;
        @(negedge clk); b_valid = 0;
        chk(b_rsp_rdata == exp, tag, b_rsp_rdata, exp);
    endtask

    task automatic pulse(input int code, input int n);
        @(negedge clk); evt_pulse[code] = 1'b1;
        repeat (n) @(negedge clk);
        evt_pulse[code] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit [31:0] lfsr;
        lfsr = 32'hACE1_2345;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(irq == 0, "R1", irq, 0);
        rd_a(16'h1D0C, 0, "R1");
        rd_a(16'h1C70, 8'hFF, "R1");
        rd_a(16'h1C78, 0, "R1");
        rd_a(16'h1CF0, VER, "R11");
        wr_a(16'h1CF0, 32'h0);
        rd_a(16'h1CF0, VER, "R11");
        rd_a(16'h1C40, 0, "R12");
        // R4 codes: counter0=0x40, c1=0x01, c2=0x02, c3=0x03, c4..7=0x04..0x07
        wr_a(16'h1C80, 32'h0302_0140);
        wr_a(16'h1C84, 32'h0706_0504);
        wr_a(16'h1C04, 32'h0000_000F);
        // R2 global off: pulses ignored
        pulse(8'h40, 5);
        rd_a(16'h1D00, 0, "R2");
        wr_a(16'h1C00, 1);
        pulse(8'h40, 5);
        rd_a(16'h1D00, 5, "R4");
        pulse(8'h05, 4);
        rd_a(16'h1D28, 0, "R3");
        pulse(8'h03, 7);
        rd_a(16'h1D18, 7, "R4");
        wr_a(16'h1C00, 0);
        pulse(8'h03, 3);
        rd_a(16'h1D18, 7, "R2");
        wr_a(16'h1C00, 1);
        // R5 preload halves
        wr_a(16'h1D14, 32'h1234_5678);
        rd_a(16'h1D14, 32'h1234_5678, "R5");
        rd_a(16'h1D10, 0, "R5");
        // R6 write against an active pulse on counter 1
        @(negedge clk); evt_pulse[8'h01] = 1;
        repeat (3) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 16'h1D08; req_wdata = 100;
        @(negedge clk); req_valid = 0; req_write = 0; evt_pulse[8'h01] = 0;
        rd_a(16'h1D08, 100, "R6");
        // R7 wrap of counter 0
        wr_a(16'h1D04, 32'hFFFF_FFFF);
        wr_a(16'h1D00, 32'hFFFF_FFFF);
        pulse(8'h40, 1);
        rd_a(16'h1D00, 0, "R7");
        rd_a(16'h1D04, 0, "R7");
        rd_a(16'h1C78, 1, "R7");
        chk(irq == 0, "R8", irq, 0);
        wr_a(16'h1C70, 32'hFE);
        chk(irq == 1, "R8", irq, 1);
        wr_a(16'h1C78, 0);
        rd_a(16'h1C78, 1, "R9");
        wr_a(16'h1C7C, 1);
        chk(irq == 0, "R9", irq, 0);
        rd_a(16'h1C78, 0, "R9");
        rd_a(16'h1C7C, 0, "R9");
        // Pseudo-random phase: several codes at once, reading all halves
        wr_a(16'h1C04, 32'hFF);
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            evt_pulse = '0;
            evt_pulse[lfsr[2:0]] = lfsr[3];
            evt_pulse[lfsr[6:4]] = lfsr[7];
            evt_pulse[8'h40] = lfsr[9];
            evt_pulse[lfsr[17:10]] = 1'b1;
            req_valid = lfsr[11]; req_write = 0;
            req_addr = 16'(16'h1D00 + 4 * (k % 16));
        end
        @(negedge clk); evt_pulse = '0; req_valid = 0;
        // R10 layout 1 instance
        wr_b(16'h1C80, 32'h0000_0020);
        wr_b(16'h1C04, 1);
        wr_b(16'h1C00, 1);
        wr_b(16'h1D04, 32'hFFFF_FFFF);
        wr_b(16'h1D00, 32'hFFFF_FFFE);
        pulse(8'h20, 2);
        rd_b(16'h1C70, 1, "R10");
        chk(b_irq == 0, "R10", b_irq, 0);
        wr_b(16'h1C74, 0);
        chk(b_irq == 1, "R10", b_irq, 1);
        rd_b(16'h1C74, 0, "R10");
        wr_b(16'h1C70, 1);
        chk(b_irq == 0, "R10", b_irq, 0);
        rd_b(16'h1C70, 0, "R10");
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule